// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a controller's transmit data line and the enable of a single-wire bus driver. In normal mode a low transmit level commands the bus dominant and a high level leaves it recessive. If the transmit line stays low for too long, the guard forces the driver recessive. A line can stay low because of a software fault, a stuck pin or an unconnected input that reads low. The guard then holds the driver recessive until the line has been high for a minimum time. This keeps one node from blocking every other node on the bus.

Both time windows are parameters counted in clock ticks. The defaults assume a 125 MHz clock: a 60 ms trip window and a 10 µs release window. A strap input switches the guard off for systems that must be able to hold a static dominant level. Outside normal mode the driver command is always recessive, and the guard state is cleared. Each entry to normal mode therefore starts fresh.

Top module: `dom_timeout_guard`

## Requirements
- R1: In normal mode, with no trip latched, `drv_dominant` equals the inverse of `txd_in` in the same cycle (low drives dominant = 1, high gives recessive = 0).
- R2: With the guard enabled, once `txd_in` has been sampled low on `TRIP_TICKS` consecutive rising edges in normal mode, the trip latches. From the next cycle `drv_dominant` is 0 even though `txd_in` is still low. A floating input that reads low is tripped like any other low.
- R3: A latched trip is released only after `txd_in` has been sampled high on `RELEASE_TICKS` consecutive edges. A low sample before that restarts the high count and keeps the driver recessive. After the release, a low drives dominant again.
- R4: When `normal_mode` is 0, `drv_dominant` is 0 whatever `txd_in` shows.
- R5: With `guard_on` = 0 the guard never trips, so a static low is held dominant indefinitely. Dropping `guard_on` also clears a latched trip at the next edge.
- R6: The low-run count restarts on every high sample and saturates at `TRIP_TICKS` rather than wrapping. If the guard is enabled after a long low run, the trip latches at the next low edge.
- R7: `timeout_flag` is 0 out of reset. It rises in the cycle the trip takes effect and falls in the cycle the release takes effect.
- R8: A cycle with `normal_mode` = 0 clears the low-run count, the high-run count and the trip latch at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock with the tick rate the parameters are counted in |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_in | input | 1 | Transmit data from the controller, low = dominant request |
| normal_mode | input | 1 | High when the transceiver is in normal mode |
| guard_on | input | 1 | Strap, high enables the dominant timeout |
| drv_dominant | output | 1 | Driver command, 1 = pull the bus dominant |
| timeout_flag | output | 1 | High while a timeout trip is latched |

## Verification
The bench sweeps every low-run length around the trip threshold, followed by every high-run length around the release threshold. This catches an off-by-one count, which would trip one cycle early or late, or release after a single high sample. It interrupts the release with a low sample, and a design that did not restart the high count would release too soon. It enables the guard after a saturated low run; a counter that wrapped or compared for equality would never trip. It also leaves normal mode while a trip is latched; a design that kept the latch would come back into normal mode already recessive. Finally, it holds a static low with the guard strapped off, where a design that ignored the strap would cut the bus off.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  // True when one more counted sample brings the run to the limit.
  function automatic logic run_completes(input int unsigned run_len, input int unsigned limit);
    return (run_len + 1) >= limit;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/dtg_run_counter.sv
module dtg_run_counter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic last_needed
);
  localparam int unsigned W = dtg_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (clear)
      run_q <= '0;
    else if (count_en && run_q < LIM_V)
      run_q <= run_q + 1'b1;
  end

  assign last_needed = dtg_pkg::run_completes(32'(run_q), LIMIT);

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIM_V); // R6
  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> run_q == '0); // R6
endmodule

// File: rtl/dtg_trip_latch.sv
module dtg_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic set_evt,
  input  logic release_evt,
  output logic tripped
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tripped <= 1'b0;
    else if (wipe)
      tripped <= 1'b0;
    else if (set_evt)
      tripped <= 1'b1;
    else if (release_evt)
      tripped <= 1'b0;
  end
endmodule

// File: rtl/dom_timeout_guard.sv
module dom_timeout_guard #(
  parameter int unsigned TRIP_TICKS    = 7_500_000,
  parameter int unsigned RELEASE_TICKS = 1_250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic normal_mode,
  input  logic guard_on,
  output logic drv_dominant,
  output logic timeout_flag
);
  logic low_last, high_last, tripped;
  logic low_clear, high_clear;
  logic trip_evt, release_evt, wipe_evt;

  assign low_clear  = !normal_mode || txd_in;
  assign high_clear = !normal_mode || !txd_in || !tripped;

  dtg_run_counter #(.LIMIT(TRIP_TICKS)) u_low_run (
    .clk(clk), .rst_n(rst_n), .clear(low_clear), .count_en(1'b1),
    .last_needed(low_last)
  );

  dtg_run_counter #(.LIMIT(RELEASE_TICKS)) u_high_run (
    .clk(clk), .rst_n(rst_n), .clear(high_clear), .count_en(1'b1),
    .last_needed(high_last)
  );

  assign wipe_evt    = !normal_mode || !guard_on;
  assign trip_evt    = !txd_in && low_last;
  assign release_evt = tripped && txd_in && high_last;

  dtg_trip_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wipe(wipe_evt), .set_evt(trip_evt),
    .release_evt(release_evt), .tripped(tripped)
  );

  assign drv_dominant = normal_mode && !txd_in && !tripped;
  assign timeout_flag = tripped;

  AST_TRIP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(!txd_in && normal_mode && guard_on)); // R2
  AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(timeout_flag) && $past(normal_mode && guard_on)) |-> $past(txd_in)); // R3
  AST_OFF_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_on |=> !timeout_flag); // R5
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_mode |=> !timeout_flag); // R8
  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && normal_mode && guard_on && !txd_in) |=> timeout_flag); // R3
endmodule

// File: tb/dom_timeout_guard_bench.sv
module dom_timeout_guard_bench;
  localparam int TRIP = 6;
  localparam int REL  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd_in = 1'b0;
  logic normal_mode = 1'b0;
  logic guard_on = 1'b1;
  logic drv_dominant, timeout_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_low = 0, m_high = 0;
  bit m_lat = 0;

  always #4 clk = ~clk;

  dom_timeout_guard #(.TRIP_TICKS(TRIP), .RELEASE_TICKS(REL)) u_dom_timeout_guard (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .normal_mode(normal_mode),
    .guard_on(guard_on), .drv_dominant(drv_dominant), .timeout_flag(timeout_flag)
  );

  task automatic chk(input string tag, input logic exp_d, input logic exp_t);
    checks++;
    if (drv_dominant !== exp_d || timeout_flag !== exp_t) begin
      failures++;
      $display("FAIL %s drv=%b exp=%b flag=%b exp=%b t=%0t", tag,
               drv_dominant, exp_d, timeout_flag, exp_t, $time);
    end
  endtask

  // One cycle: drive inputs, check outputs against the model, advance the model.
  task automatic step(input logic tx, input logic nm, input logic ge, input string tag);
    txd_in = tx; normal_mode = nm; guard_on = ge;
    #1;
    chk(tag, nm && !tx && !m_lat, m_lat);
    @(posedge clk);
    if (!nm) begin
      m_low = 0; m_high = 0; m_lat = 0;
    end else if (tx) begin
      m_low = 0;
      if (m_lat) begin
        m_high++;
        if (m_high >= REL) begin m_lat = 0; m_high = 0; end
      end else m_high = 0;
    end else begin
      m_high = 0;
      m_low++;
      if (ge && m_low >= TRIP) m_lat = 1;
    end
    if (!ge) m_lat = 0;
    if (!m_lat) m_high = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; chk("R7 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2/R3/R7: low runs around the trip length, high runs around release.
    for (int ge = 0; ge < 2; ge++)
      for (int lo = 1; lo <= TRIP + 3; lo++)
        for (int hi = 1; hi <= REL + 2; hi++) begin
          for (int k = 0; k < lo; k++) step(1'b0, 1'b1, ge[0], "R2 low run");
          for (int k = 0; k < hi; k++) step(1'b1, 1'b1, ge[0], "R3 high run");
          step(1'b0, 1'b1, ge[0], "R1 low after high");
          for (int k = 0; k < REL + 1; k++) step(1'b1, 1'b1, ge[0], "R1 recessive");
        end

    // R3: interrupted release restarts the high count.
    for (int k = 0; k < TRIP + 1; k++) step(1'b0, 1'b1, 1'b1, "R2 trip");
    for (int k = 0; k < REL - 1; k++) step(1'b1, 1'b1, 1'b1, "R3 partial high");
    step(1'b0, 1'b1, 1'b1, "R3 low keeps recessive");
    for (int k = 0; k < REL + 1; k++) step(1'b1, 1'b1, 1'b1, "R3 full high");
    step(1'b0, 1'b1, 1'b1, "R3 dominant again");

    // R5/R6: long static low with guard off, then enable the guard.
    for (int k = 0; k < 3 * TRIP; k++) step(1'b0, 1'b1, 1'b0, "R5 static low");
    step(1'b0, 1'b1, 1'b1, "R6 enable after saturation");
    step(1'b0, 1'b1, 1'b1, "R6 tripped next edge");
    step(1'b0, 1'b1, 1'b0, "R5 strap off clears");
    step(1'b0, 1'b1, 1'b0, "R5 dominant after clear");

    // R4/R8: leave normal mode while tripped, come back clean.
    for (int k = 0; k < TRIP + 1; k++) step(1'b0, 1'b1, 1'b1, "R2 trip again");
    step(1'b0, 1'b0, 1'b1, "R4 out of normal");
    step(1'b0, 1'b0, 1'b1, "R8 latch cleared");
    for (int k = 0; k < TRIP + 1; k++) step(1'b0, 1'b1, 1'b1, "R8 fresh count");
    step(1'b1, 1'b0, 1'b1, "R4 high out of normal");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule